// File: doc/BRIEF.md
# Message Buffer Ownership Controller

This block keeps a small pool of message buffers for a processor that runs numbered tasks. Each buffer holds 64 message registers and carries an owner tag. The task that is running sends requests on one request channel. It can claim a free buffer, give its buffer back, or read or write one register of the buffer it holds. Every accepted request gets one response, which carries a status code, the buffer index and, for reads, the register value.

A second input, a handover command, comes from the messaging rendezvous logic when a message goes from one task to another. The command moves the owner tag of the sender's buffer to the receiver. From then on the receiver can read the registers, and the receiver is the task that must release the buffer. Only the task named in a buffer's tag can reach that buffer's registers. A task holds at most one buffer at a time.

Flow control works as follows. The request channel uses valid/ready. `req_ready` drops in every cycle where `xfer_valid` is high, because the handover takes that cycle, and a request held during that cycle stays pending until ready returns. The response side has no back-pressure. `rsp_valid` pulses for exactly one cycle, one clock after a request is accepted, and the consumer must take the response then.

Top module: `mbx_own_ctrl`

## Requirements
- R1: A claim request (op code 0) from a task that holds no buffer, while a buffer is free, is granted the lowest-numbered free buffer. The response carries status 0 (ok) and that index on `rsp_buf`.
- R2: A claim request from a task that already holds a buffer returns status 2 (already holding), and no ownership changes.
- R3: A claim request while all buffers are taken returns status 1 (pool empty), and no ownership changes.
- R4: A release request (op code 1) by the holder returns status 0 and frees the buffer. After the release, the task's register accesses return status 3, and a later claim can be granted that buffer.
- R5: A read (op 2), write (op 3) or release by a task that holds no buffer returns status 3 (no buffer) with `rsp_rdata` zero, and writes nothing.
- R6: A write stores `req_wdata` into register `req_idx` of the requester's buffer. A read returns the stored value. The response of every accepted request appears exactly one clock after acceptance, and `rsp_valid` stays low in cycles that follow no acceptance.
- R7: Register accesses by a task reach only the buffer that the task holds. Equal indices in different buffers keep independent values.
- R8: A handover whose sender holds a buffer and whose receiver holds none moves the tag to the receiver. `xfer_done` and `xfer_ok` are both high one clock later. The receiver then sees the buffer contents, and the sender gets status 3.
- R9: A handover whose sender holds no buffer, or whose receiver already holds one, reports `xfer_ok` low with `xfer_done` high, and changes no tag.
- R10: While `xfer_valid` is high, `req_ready` is low, and a request presented in that cycle is not carried out.
- R11: After reset, all buffers are free, `rsp_valid` and `xfer_done` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 2 | 0 claim, 1 release, 2 read, 3 write |
| req_task | input | TASK_W | Requesting task number |
| req_idx | input | log2(NUM_REGS) | Message register index |
| req_wdata | input | DATA_W | Write value |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 ok, 1 pool empty, 2 already holding, 3 no buffer |
| rsp_buf | output | log2(NUM_BUFS) | Buffer index (meaningful on ok) |
| rsp_rdata | output | DATA_W | Read value, zero for other ops |
| xfer_valid | input | 1 | Handover command |
| xfer_from | input | TASK_W | Sending task |
| xfer_to | input | TASK_W | Receiving task |
| xfer_done | output | 1 | Handover result pulse |
| xfer_ok | output | 1 | Handover was applied |

## Verification
The bench sends claims from all eight tasks in order. This shows lowest-index allocation apart from the pool-empty response. It then fills every register of every buffer with a value that depends on both the buffer and the index, and reads each one back. A mix-up of buffer bits and index bits then produces a wrong value instead of a lucky match. Handovers are tried in good and bad combinations of sender and receiver, and one handover is made to collide with a pending write, which separates the back-pressure rule from plain arbitration. Accesses by tasks that hold no buffer are followed by reads through the real holders, which shows that nothing was written.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    OP_GRAB  = 2'd0,
    OP_DROP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_STORE = 2'd3
  } mbx_op_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_EMPTY = 2'd1,
    ST_HELD  = 2'd2,
    ST_NOBUF = 2'd3
  } mbx_st_e;
endpackage

// File: rtl/mbx_owner_tab.sv
// Owner tag per buffer, with task lookups and a lowest-free search.
module mbx_owner_tab #(
  parameter int NB = 4,
  parameter int TW = 3,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] q_task,
  input  logic [TW-1:0] x_from,
  input  logic [TW-1:0] x_to,
  input  logic          cap_en,
  input  logic [BW-1:0] cap_buf,
  input  logic [TW-1:0] cap_task,
  input  logic          rel_en,
  input  logic [BW-1:0] rel_buf,
  input  logic          mv_en,
  input  logic [BW-1:0] mv_buf,
  input  logic [TW-1:0] mv_task,
  output logic          q_hit,
  output logic [BW-1:0] q_buf,
  output logic          from_hit,
  output logic [BW-1:0] from_buf,
  output logic          to_hit,
  output logic          free_any,
  output logic [BW-1:0] free_buf,
  output logic [NB-1:0] used_o,
  output logic [NB*TW-1:0] own_flat
);
  logic [NB-1:0] used_q;
  logic [TW-1:0] own_q [NB];

  for (genvar b = 0; b < NB; b++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        used_q[b] <= 1'b0;
        own_q[b]  <= '0;
      end else if (cap_en && cap_buf == BW'(b)) begin
        used_q[b] <= 1'b1;
        own_q[b]  <= cap_task;
      end else if (rel_en && rel_buf == BW'(b)) begin
        used_q[b] <= 1'b0;
      end else if (mv_en && mv_buf == BW'(b)) begin
        own_q[b]  <= mv_task;
      end
    end
    assign own_flat[b*TW +: TW] = own_q[b];
  end

  always_comb begin
    q_hit    = 1'b0;
    q_buf    = '0;
    from_hit = 1'b0;
    from_buf = '0;
    to_hit   = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (used_q[b] && own_q[b] == q_task) begin
        q_hit = 1'b1;
        q_buf = BW'(b);
      end
      if (used_q[b] && own_q[b] == x_from) begin
        from_hit = 1'b1;
        from_buf = BW'(b);
      end
      if (used_q[b] && own_q[b] == x_to) to_hit = 1'b1;
    end
  end

  // descending scan so that the lowest free index wins
  always_comb begin
    free_buf = '0;
    for (int b = NB - 1; b >= 0; b--) begin
      if (!used_q[b]) free_buf = BW'(b);
    end
  end

  assign free_any = ~&used_q;
  assign used_o   = used_q;
endmodule

// File: rtl/mbx_reg_store.sv
// Register storage of all buffers, addressed {buffer, index}; reads are registered.
module mbx_reg_store #(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
    else         rdata <= '0;
  end
endmodule

// File: rtl/mbx_req_dec.sv
// Turns an accepted request and the lookup results into a status and enables.
module mbx_req_dec
  import mbx_pkg::*;
(
  input  logic    take,
  input  mbx_op_e op,
  input  logic    hit,
  input  logic    free_any,
  output mbx_st_e status,
  output logic    cap_en,
  output logic    rel_en,
  output logic    we,
  output logic    re
);
  always_comb begin
    status = ST_OK;
    cap_en = 1'b0;
    rel_en = 1'b0;
    we     = 1'b0;
    re     = 1'b0;
    unique case (op)
      OP_GRAB: begin
        if (hit)            status = ST_HELD;
        else if (!free_any) status = ST_EMPTY;
        else                cap_en = take;
      end
      OP_DROP: begin
        if (hit) rel_en = take;
        else     status = ST_NOBUF;
      end
      OP_LOAD: begin
        if (hit) re = take;
        else     status = ST_NOBUF;
      end
      OP_STORE: begin
        if (hit) we = take;
        else     status = ST_NOBUF;
      end
      default: status = ST_NOBUF;
    endcase
  end
endmodule

// File: rtl/mbx_own_ctrl.sv
module mbx_own_ctrl
  import mbx_pkg::*;
#(
  parameter int NUM_BUFS = 4,
  parameter int NUM_REGS = 64,   // power of two
  parameter int DATA_W   = 16,
  parameter int TASK_W   = 3,
  localparam int BW = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
  localparam int IW = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [TASK_W-1:0] req_task,
  input  logic [IW-1:0]     req_idx,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [BW-1:0]     rsp_buf,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              xfer_valid,
  input  logic [TASK_W-1:0] xfer_from,
  input  logic [TASK_W-1:0] xfer_to,
  output logic              xfer_done,
  output logic              xfer_ok
);
  localparam int DEPTH = NUM_BUFS * NUM_REGS;
  localparam int AW    = $clog2(DEPTH);

  logic            take;
  mbx_op_e         op;
  mbx_st_e         st;
  logic            cap_en, rel_en, we, re, mv_en;
  logic            q_hit, from_hit, to_hit, free_any;
  logic [BW-1:0]   q_buf, from_buf, free_buf, buf_sel;
  logic [NUM_BUFS-1:0]        used_v;
  logic [NUM_BUFS*TASK_W-1:0] own_flat;
  logic [AW-1:0]   addr;

  // a handover owns the cycle; requests wait
  assign req_ready = ~xfer_valid;
  assign take      = req_valid & req_ready;
  assign op        = mbx_op_e'(req_op);
  assign mv_en     = xfer_valid & from_hit & ~to_hit;
  assign addr      = AW'({q_buf, req_idx});
  assign buf_sel   = (op == OP_GRAB) ? free_buf : q_buf;

  mbx_owner_tab #(.NB(NUM_BUFS), .TW(TASK_W)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .q_task(req_task), .x_from(xfer_from), .x_to(xfer_to),
    .cap_en(cap_en), .cap_buf(free_buf), .cap_task(req_task),
    .rel_en(rel_en), .rel_buf(q_buf),
    .mv_en(mv_en), .mv_buf(from_buf), .mv_task(xfer_to),
    .q_hit(q_hit), .q_buf(q_buf),
    .from_hit(from_hit), .from_buf(from_buf), .to_hit(to_hit),
    .free_any(free_any), .free_buf(free_buf),
    .used_o(used_v), .own_flat(own_flat)
  );

  mbx_req_dec u_dec (
    .take(take), .op(op), .hit(q_hit), .free_any(free_any),
    .status(st), .cap_en(cap_en), .rel_en(rel_en), .we(we), .re(re)
  );

  mbx_reg_store #(.DEPTH(DEPTH), .DW(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(we), .waddr(addr), .wdata(req_wdata),
    .re(re), .raddr(addr), .rdata(rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= '0;
      rsp_buf    <= '0;
      xfer_done  <= 1'b0;
      xfer_ok    <= 1'b0;
    end else begin
      rsp_valid  <= take;
      rsp_status <= st;
      rsp_buf    <= buf_sel;
      xfer_done  <= xfer_valid;
      xfer_ok    <= mv_en;
    end
  end
endmodule

// File: rtl/mbx_own_chk.sv
module mbx_own_chk #(
  parameter int NB = 4,
  parameter int TW = 3,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          xfer_valid,
  input logic          rsp_valid,
  input logic [1:0]    rsp_status,
  input logic [DW-1:0] rsp_rdata,
  input logic          xfer_done,
  input logic          xfer_ok,
  input logic [NB-1:0] used,
  input logic [NB*TW-1:0] own_flat
);
  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int a = 0; a < NB; a++)
      for (int b = a + 1; b < NB; b++)
        if (used[a] && used[b] && own_flat[a*TW +: TW] == own_flat[b*TW +: TW])
          dup = 1'b1;
  end

  // R10
  backpress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> !req_ready);
  // R6
  rsp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R6
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);
  // R5
  nobuf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd3) |-> rsp_rdata == '0);
  // R3
  claim_fail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_status == 2'd1 || rsp_status == 2'd2)) |->
      (used == $past(used) && own_flat == $past(own_flat)));
  // R8
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup);
  // R9
  xfer_fail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !xfer_ok) |-> (own_flat == $past(own_flat) && used == $past(used)));
endmodule

bind mbx_own_ctrl mbx_own_chk #(.NB(NUM_BUFS), .TW(TASK_W), .DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .xfer_valid(xfer_valid), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
  .rsp_rdata(rsp_rdata), .xfer_done(xfer_done), .xfer_ok(xfer_ok),
  .used(used_v), .own_flat(own_flat)
);

// File: tb/sim_mbx_own_ctrl.sv
`timescale 1ns/100ps
module sim_mbx_own_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [2:0] req_task = '0;
  logic [5:0] req_idx = '0;
  logic [15:0] req_wdata = '0;
  logic rsp_valid;
  logic [1:0] rsp_status;
  logic [1:0] rsp_buf;
  logic [15:0] rsp_rdata;
  logic xfer_valid = 1'b0;
  logic [2:0] xfer_from = '0, xfer_to = '0;
  logic xfer_done, xfer_ok;

  int n_chk = 0, n_bad = 0;
  int r_v, r_st, r_buf, r_dat, x_d, x_ok;

  always #2.5 clk = ~clk;

  mbx_own_ctrl u0 (.*);

  function automatic int pat(int b, int i);
    return (b * 977 + i * 131 + 17) & 16'hFFFF;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input int op, input int t, input int idx, input int wd);
    @(negedge clk);
    req_valid = 1'b1; req_op = op[1:0]; req_task = t[2:0];
    req_idx = idx[5:0]; req_wdata = wd[15:0];
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r_v = rsp_valid; r_st = rsp_status; r_buf = rsp_buf; r_dat = rsp_rdata;
  endtask

  task automatic do_xfer(input int f, input int t);
    @(negedge clk);
    xfer_valid = 1'b1; xfer_from = f[2:0]; xfer_to = t[2:0];
    @(posedge clk);
    @(negedge clk);
    xfer_valid = 1'b0;
    x_d = xfer_done; x_ok = xfer_ok;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(rsp_valid == 1'b0 && xfer_done == 1'b0, "R11 idle outputs", rsp_valid, 0);
    chk(req_ready == 1'b1, "R11 ready", req_ready, 1);

    // R5 accesses with no buffer held
    do_req(2, 3, 7, 0);
    chk(r_v == 1 && r_st == 3 && r_dat == 0, "R5 read nobuf", r_st, 3);
    do_req(3, 3, 7, 16'h1234);
    chk(r_st == 3, "R5 write nobuf", r_st, 3);
    do_req(1, 3, 0, 0);
    chk(r_st == 3, "R5 release nobuf", r_st, 3);

    // R1 / R3 claim sweep over all tasks
    for (int t = 0; t < 8; t++) begin
      do_req(0, t, 0, 0);
      if (t < 4) chk(r_st == 0 && r_buf == t, "R1 claim lowest free", r_buf, t);
      else       chk(r_st == 1, "R3 pool empty", r_st, 1);
    end
    // R2
    do_req(0, 2, 0, 0);
    chk(r_st == 2, "R2 already holding", r_st, 2);

    // R6 / R7 fill every register of every buffer
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 64; i++) begin
        do_req(3, t, i, pat(t, i));
        if (r_v != 1 || r_st != 0) chk(0, "R6 write status", r_st, 0);
      end
    // R5 a non-holder write must not land anywhere
    do_req(3, 6, 5, 16'hFFFF);
    chk(r_st == 3, "R5 stray write status", r_st, 3);
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 64; i++) begin
        do_req(2, t, i, 0);
        n_chk++;
        if (r_v != 1 || r_st != 0 || r_dat != pat(t, i)) begin
          n_bad++;
          $display("FAIL R6 R7 readback t=%0d i=%0d act=%0h exp=%0h", t, i, r_dat, pat(t, i));
        end
      end

    // R8 good handover 1 -> 6
    do_xfer(1, 6);
    chk(x_d == 1 && x_ok == 1, "R8 handover ok", x_ok, 1);
    do_req(2, 6, 10, 0);
    chk(r_st == 0 && r_dat == pat(1, 10), "R8 receiver sees data", r_dat, pat(1, 10));
    do_req(2, 1, 10, 0);
    chk(r_st == 3, "R8 sender lost buffer", r_st, 3);

    // R9 bad handovers
    do_xfer(7, 5);
    chk(x_d == 1 && x_ok == 0, "R9 sender holds none", x_ok, 0);
    do_xfer(0, 6);
    chk(x_d == 1 && x_ok == 0, "R9 receiver holds one", x_ok, 0);
    do_req(2, 0, 3, 0);
    chk(r_dat == pat(0, 3), "R9 sender kept buffer", r_dat, pat(0, 3));
    do_req(2, 6, 3, 0);
    chk(r_dat == pat(1, 3), "R9 receiver unchanged", r_dat, pat(1, 3));

    // R10 handover collides with a write request
    @(negedge clk);
    xfer_valid = 1'b1; xfer_from = 3'd2; xfer_to = 3'd7;
    req_valid = 1'b1; req_op = 2'd3; req_task = 3'd2; req_idx = 6'd0; req_wdata = 16'hAAAA;
    #1;
    chk(req_ready == 1'b0, "R10 ready low", req_ready, 0);
    @(posedge clk);
    @(negedge clk);
    xfer_valid = 1'b0; req_valid = 1'b0;
    chk(rsp_valid == 1'b0, "R10 no response", rsp_valid, 0);
    chk(xfer_ok == 1'b1, "R10 handover applied", xfer_ok, 1);
    do_req(2, 7, 0, 0);
    chk(r_dat == pat(2, 0), "R10 write not done", r_dat, pat(2, 0));

    // R4 release and reuse
    do_req(1, 6, 0, 0);
    chk(r_st == 0, "R4 release ok", r_st, 0);
    do_req(2, 6, 0, 0);
    chk(r_st == 3, "R4 access after release", r_st, 3);
    do_req(1, 6, 0, 0);
    chk(r_st == 3, "R4 double release", r_st, 3);
    do_req(0, 4, 0, 0);
    chk(r_st == 0 && r_buf == 1, "R4 freed buffer reused", r_buf, 1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule